// File: doc/BRIEF.md
# Adaptive Prefetch Slip Controller

This block limits how far ahead a prefetching engine may run in front of the consumer that later issues the matching loads. The prefetcher puts one token for each prefetch group it launches. The consumer takes one token for each load group. When the number of outstanding tokens reaches the current depth limit, the prefetcher is held off.

The depth limit is not fixed. The controller watches one outcome pulse for each completed prefetch. A prefetch is late if its data came back after the consumer had already issued the load. It is useful if the data arrived first. After every window of 64 outcomes the controller compares the two tallies and moves the limit up or down by one step. While the prefetch buffer (eight entries) reports full at the moment of evaluation, the limit is left alone. Late prefetches therefore let the engine run further ahead, and a stream of timely ones pulls it back.

Top module: `slip_ctrl`

## Requirements
- R1: While reset is applied and in the first cycle after it is released, occupancy is 0, the depth limit is 4, and both stalls are low when no request is present.
- R2: An allowed put raises occupancy by one at the next clock edge. An allowed get (occupancy above 0) lowers it by one at the next clock edge.
- R3: While occupancy is at or above the depth limit, a put request asserts `prod_stall` in the same cycle and is refused, so the put itself adds nothing to occupancy.
- R4: A get request while occupancy is 0 asserts `cons_stall` in the same cycle and leaves occupancy unchanged.
- R5: A put and a get in the same cycle that are both allowed leave occupancy unchanged.
- R6: An outcome is a cycle with `late_hit` or `useful_hit` high. If both are high in one cycle, it is one late outcome. The 64th outcome since the last evaluation triggers an evaluation that includes that outcome and clears both tallies. The new limit is visible from the next cycle.
- R7: If `pfb_full` is high in the evaluating cycle, the depth limit is unchanged.
- R8: Otherwise, when twice the late tally is greater than the useful tally, the limit rises by one.
- R9: In every other case the limit falls by one.
- R10: The limit stays within 1 to 16. A rise at 16 or a fall at 1 leaves it unchanged.
- R11: The limit changes only at an evaluation and by at most one step. Lowering it never removes tokens already in the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| put_req | input | 1 | Prefetcher asks to add a token |
| get_req | input | 1 | Consumer asks to take a token |
| late_hit | input | 1 | Outcome pulse: prefetch data arrived after its load |
| useful_hit | input | 1 | Outcome pulse: prefetch data arrived before its load |
| pfb_full | input | 1 | Prefetch buffer full flag, freezes retuning |
| prod_stall | output | 1 | Put request refused this cycle |
| cons_stall | output | 1 | Get request refused this cycle |
| occupancy | output | 5 | Tokens currently held |
| depth_limit | output | 5 | Current run-ahead limit |

## Verification
On every cycle the assertions check these cycle-level rules:
- the stalls agree with occupancy and the limit;
- refused and balanced requests leave occupancy alone;
- the limit stays inside its range and moves only at an evaluation, by one step;
- a full buffer freezes the limit.

Whether the step went the right way depends on a whole window of tallies, so only the bench scenarios show it:
- the boundary split of 21 late against 43 useful, and 22 late against 42 useful;
- a window of late and useful pulses arriving together;
- the climb to 16 and the descent to 1;
- a queue of 16 tokens that survives the limit falling to 1.

// File: rtl/slip_pkg.sv
`timescale 1ns/1ps
package slip_pkg;

  // Direction chosen for the depth limit at an evaluation
  typedef enum logic [1:0] {
    ADJ_HOLD  = 2'd0,
    ADJ_RAISE = 2'd1,
    ADJ_LOWER = 2'd2
  } adj_e;

endpackage

// File: rtl/slip_token_queue.sv
`timescale 1ns/1ps
module slip_token_queue #(
  parameter int OCC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             put_req,
  input  logic             get_req,
  input  logic [OCC_W-1:0] limit,
  output logic             put_stall,
  output logic             get_stall,
  output logic [OCC_W-1:0] occ
);

  logic [OCC_W-1:0] occ_q;
  logic [OCC_W-1:0] occ_nxt;
  logic             put_ok;
  logic             get_ok;
  logic             occ_en;

  // Admission decisions against the current limit and fill
  always_comb begin
    put_ok    = put_req && (occ_q < limit);
    get_ok    = get_req && (occ_q != '0);
    put_stall = put_req && !put_ok;
    get_stall = get_req && !get_ok;
  end

  // Occupancy moves only when exactly one side is admitted
  always_comb begin
    occ_en  = put_ok ^ get_ok;
    occ_nxt = occ_q;
    if (put_ok && !get_ok) begin
      occ_nxt = occ_q + {{(OCC_W-1){1'b0}}, 1'b1};
    end else if (get_ok && !put_ok) begin
      occ_nxt = occ_q - {{(OCC_W-1){1'b0}}, 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q <= '0;
    end else if (occ_en) begin
      occ_q <= occ_nxt;
    end
  end

  assign occ = occ_q;

endmodule

// File: rtl/slip_outcome_tally.sv
`timescale 1ns/1ps
module slip_outcome_tally #(
  parameter int WINDOW = 64,
  parameter int CNT_W  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             late_hit,
  input  logic             useful_hit,
  output logic             eval_fire,
  output logic [CNT_W-1:0] late_total,
  output logic [CNT_W-1:0] useful_total
);

  localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(WINDOW - 1);

  logic [CNT_W-1:0] late_q;
  logic [CNT_W-1:0] useful_q;
  logic [CNT_W-1:0] seen_q;
  logic [CNT_W-1:0] late_nxt;
  logic [CNT_W-1:0] useful_nxt;
  logic [CNT_W-1:0] seen_nxt;
  logic             outcome;
  logic             is_late;
  logic             is_useful;
  logic             tally_en;

  // One outcome per cycle; a late report wins over a useful one
  always_comb begin
    outcome   = late_hit || useful_hit;
    is_late   = late_hit;
    is_useful = useful_hit && !late_hit;
  end

  // Totals include the outcome of the present cycle
  always_comb begin
    late_total   = late_q   + {{(CNT_W-1){1'b0}}, is_late};
    useful_total = useful_q + {{(CNT_W-1){1'b0}}, is_useful};
    eval_fire    = outcome && (seen_q == LAST_SLOT);
  end

  always_comb begin
    tally_en   = outcome;
    late_nxt   = late_total;
    useful_nxt = useful_total;
    seen_nxt   = seen_q + {{(CNT_W-1){1'b0}}, 1'b1};
    if (eval_fire) begin
      late_nxt   = '0;
      useful_nxt = '0;
      seen_nxt   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      late_q   <= '0;
      useful_q <= '0;
      seen_q   <= '0;
    end else if (tally_en) begin
      late_q   <= late_nxt;
      useful_q <= useful_nxt;
      seen_q   <= seen_nxt;
    end
  end

endmodule

// File: rtl/slip_depth_governor.sv
`timescale 1ns/1ps
module slip_depth_governor
  import slip_pkg::*;
#(
  parameter int MIN_DEPTH  = 1,
  parameter int MAX_DEPTH  = 16,
  parameter int INIT_DEPTH = 4,
  parameter int LIM_W      = 5,
  parameter int CNT_W      = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eval_fire,
  input  logic             hold,
  input  logic [CNT_W-1:0] late_total,
  input  logic [CNT_W-1:0] useful_total,
  output logic [LIM_W-1:0] limit
);

  localparam logic [LIM_W-1:0] LIM_MIN  = LIM_W'(MIN_DEPTH);
  localparam logic [LIM_W-1:0] LIM_MAX  = LIM_W'(MAX_DEPTH);
  localparam logic [LIM_W-1:0] LIM_INIT = LIM_W'(INIT_DEPTH);

  logic [LIM_W-1:0] lim_q;
  logic [LIM_W-1:0] lim_nxt;
  logic [CNT_W:0]   late_x2;
  logic [CNT_W:0]   useful_ext;
  logic             lim_en;
  adj_e             adj;

  // Direction: hold while the buffer is full, else compare 2*late with useful
  always_comb begin
    late_x2    = {late_total, 1'b0};
    useful_ext = {1'b0, useful_total};
    if (hold) begin
      adj = ADJ_HOLD;
    end else if (late_x2 > useful_ext) begin
      adj = ADJ_RAISE;
    end else begin
      adj = ADJ_LOWER;
    end
  end

  // Saturating single step
  always_comb begin
    lim_en  = eval_fire;
    lim_nxt = lim_q;
    unique case (adj)
      ADJ_RAISE: if (lim_q < LIM_MAX) lim_nxt = lim_q + {{(LIM_W-1){1'b0}}, 1'b1};
      ADJ_LOWER: if (lim_q > LIM_MIN) lim_nxt = lim_q - {{(LIM_W-1){1'b0}}, 1'b1};
      default:   lim_nxt = lim_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q <= LIM_INIT;
    end else if (lim_en) begin
      lim_q <= lim_nxt;
    end
  end

  assign limit = lim_q;

endmodule

// File: rtl/slip_ctrl.sv
`timescale 1ns/1ps
module slip_ctrl #(
  parameter int MIN_DEPTH  = 1,
  parameter int MAX_DEPTH  = 16,
  parameter int INIT_DEPTH = 4,
  parameter int WINDOW     = 64,
  localparam int LIM_W     = $clog2(MAX_DEPTH + 1),
  localparam int CNT_W     = $clog2(WINDOW + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             put_req,
  input  logic             get_req,
  input  logic             late_hit,
  input  logic             useful_hit,
  input  logic             pfb_full,
  output logic             prod_stall,
  output logic             cons_stall,
  output logic [LIM_W-1:0] occupancy,
  output logic [LIM_W-1:0] depth_limit
);

  logic             eval_fire;
  logic [CNT_W-1:0] late_total;
  logic [CNT_W-1:0] useful_total;

  slip_token_queue #(
    .OCC_W (LIM_W)
  ) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .put_req   (put_req),
    .get_req   (get_req),
    .limit     (depth_limit),
    .put_stall (prod_stall),
    .get_stall (cons_stall),
    .occ       (occupancy)
  );

  slip_outcome_tally #(
    .WINDOW (WINDOW),
    .CNT_W  (CNT_W)
  ) u_tally (
    .clk          (clk),
    .rst_n        (rst_n),
    .late_hit     (late_hit),
    .useful_hit   (useful_hit),
    .eval_fire    (eval_fire),
    .late_total   (late_total),
    .useful_total (useful_total)
  );

  slip_depth_governor #(
    .MIN_DEPTH  (MIN_DEPTH),
    .MAX_DEPTH  (MAX_DEPTH),
    .INIT_DEPTH (INIT_DEPTH),
    .LIM_W      (LIM_W),
    .CNT_W      (CNT_W)
  ) u_gov (
    .clk          (clk),
    .rst_n        (rst_n),
    .eval_fire    (eval_fire),
    .hold         (pfb_full),
    .late_total   (late_total),
    .useful_total (useful_total),
    .limit        (depth_limit)
  );

endmodule

// File: rtl/slip_ctrl_chk.sv
`timescale 1ns/1ps
module slip_ctrl_chk #(
  parameter int MIN_DEPTH = 1,
  parameter int MAX_DEPTH = 16,
  parameter int LIM_W     = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             put_req,
  input logic             get_req,
  input logic             pfb_full,
  input logic             eval_fire,
  input logic             prod_stall,
  input logic             cons_stall,
  input logic [LIM_W-1:0] occupancy,
  input logic [LIM_W-1:0] depth_limit
);

  AST_PUT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    prod_stall == (put_req && (occupancy >= depth_limit))); // R3

  AST_PUT_REFUSED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (prod_stall && !get_req) |=> $stable(occupancy)); // R3

  AST_EMPTY_GET: assert property (@(posedge clk) disable iff (!rst_n)
    cons_stall == (get_req && (occupancy == '0))); // R4

  AST_EMPTY_GET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cons_stall && !put_req) |=> (occupancy == '0)); // R4

  AST_BALANCED: assert property (@(posedge clk) disable iff (!rst_n)
    (put_req && get_req && !prod_stall && !cons_stall) |=> $stable(occupancy)); // R5

  AST_FULL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_fire && pfb_full) |=> $stable(depth_limit)); // R7

  AST_LIMIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (depth_limit >= LIM_W'(MIN_DEPTH)) && (depth_limit <= LIM_W'(MAX_DEPTH))); // R10

  AST_LIMIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_fire |=> $stable(depth_limit)); // R11

  AST_LIMIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(depth_limit) |->
      ((depth_limit == $past(depth_limit) + LIM_W'(1)) ||
       (depth_limit == $past(depth_limit) - LIM_W'(1)))); // R11

  AST_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (!get_req && (occupancy != '0)) |=> (occupancy >= $past(occupancy))); // R11

endmodule

bind slip_ctrl slip_ctrl_chk #(
  .MIN_DEPTH (MIN_DEPTH),
  .MAX_DEPTH (MAX_DEPTH),
  .LIM_W     (LIM_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .put_req     (put_req),
  .get_req     (get_req),
  .pfb_full    (pfb_full),
  .eval_fire   (eval_fire),
  .prod_stall  (prod_stall),
  .cons_stall  (cons_stall),
  .occupancy   (occupancy),
  .depth_limit (depth_limit)
);

// File: tb/sim_slip_ctrl.sv
`timescale 1ns/1ps
module sim_slip_ctrl;

  localparam int LIM_MIN  = 1;
  localparam int LIM_MAX  = 16;
  localparam int LIM_INIT = 4;
  localparam int WIN      = 64;

  logic       clk;
  logic       rst_n;
  logic       put_req, get_req, late_hit, useful_hit, pfb_full;
  logic       prod_stall, cons_stall;
  logic [4:0] occupancy, depth_limit;

  int checks;
  int fails;
  bit done;

  // reference state
  int m_occ, m_lim, m_late, m_use, m_seen;

  slip_ctrl u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .put_req     (put_req),
    .get_req     (get_req),
    .late_hit    (late_hit),
    .useful_hit  (useful_hit),
    .pfb_full    (pfb_full),
    .prod_stall  (prod_stall),
    .cons_stall  (cons_stall),
    .occupancy   (occupancy),
    .depth_limit (depth_limit)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int f_next_occ(int occ, int lim, bit p, bit g);
    bit pok = p && (occ < lim);
    bit gok = g && (occ > 0);
    return occ + (pok ? 1 : 0) - (gok ? 1 : 0);
  endfunction

  function automatic int f_next_lim(int lim, int nl, int nu, bit full);
    if (full) return lim;
    if (2 * nl > nu) return (lim < LIM_MAX) ? lim + 1 : lim;
    return (lim > LIM_MIN) ? lim - 1 : lim;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // One cycle: drive at negedge, check stalls, then check registered state after posedge
  task automatic step(input bit p, input bit g, input bit l, input bit u,
                      input bit f, input string t_occ);
    int nl, nu, nxt_lim;
    @(negedge clk);
    put_req = p; get_req = g; late_hit = l; useful_hit = u; pfb_full = f;
    #1;
    check("R3 prod_stall", int'(prod_stall), int'(p && (m_occ >= m_lim)));
    check("R4 cons_stall", int'(cons_stall), int'(g && (m_occ == 0)));
    nxt_lim = m_lim;
    if (l || u) begin
      nl = m_late + (l ? 1 : 0);
      nu = m_use + ((u && !l) ? 1 : 0);
      if (m_seen == WIN - 1) begin
        nxt_lim = f_next_lim(m_lim, nl, nu, f);
        m_late = 0; m_use = 0; m_seen = 0;
      end else begin
        m_late = nl; m_use = nu; m_seen++;
      end
    end
    m_occ = f_next_occ(m_occ, m_lim, p, g);
    m_lim = nxt_lim;
    @(posedge clk);
    #1;
    check(t_occ, int'(occupancy), m_occ);
    check("R6 limit", int'(depth_limit), m_lim);
  endtask

  task automatic run_window(input int nlate, input int nuse, input int nboth, input bit f);
    for (int i = 0; i < nlate; i++) step(0, 0, 1, 0, f, "R2");
    for (int i = 0; i < nuse; i++)  step(0, 0, 0, 1, f, "R2");
    for (int i = 0; i < nboth; i++) step(0, 0, 1, 1, f, "R2");
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    checks = 0; fails = 0; done = 0;
    m_occ = 0; m_lim = LIM_INIT; m_late = 0; m_use = 0; m_seen = 0;
    rst_n = 1'b0;
    put_req = 0; get_req = 0; late_hit = 0; useful_hit = 0; pfb_full = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 occ in reset", int'(occupancy), 0);
    check("R1 limit in reset", int'(depth_limit), LIM_INIT);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 occ", int'(occupancy), 0);
    check("R1 limit", int'(depth_limit), LIM_INIT);
    check("R1 prod_stall", int'(prod_stall), 0);
    check("R1 cons_stall", int'(cons_stall), 0);

    // fill to the limit, then a refused put
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 0, "R2");
    check("R2 filled", int'(occupancy), 4);
    step(1, 0, 0, 0, 0, "R3");
    check("R3 refused put", int'(occupancy), 4);
    // refused put with allowed get, then a balanced pair
    step(1, 1, 0, 0, 0, "R2");
    step(1, 1, 0, 0, 0, "R5");
    check("R5 balanced", int'(occupancy), 3);
    // drain and try an empty get
    for (int i = 0; i < 3; i++) step(0, 1, 0, 0, 0, "R2");
    step(0, 1, 0, 0, 0, "R4");
    check("R4 empty get", int'(occupancy), 0);
    step(1, 1, 0, 0, 0, "R4");
    check("R4 put with empty get", int'(occupancy), 1);
    step(0, 1, 0, 0, 0, "R2");

    // retuning windows
    run_window(64, 0, 0, 0);
    check("R8 all late raises", int'(depth_limit), 5);
    run_window(64, 0, 0, 1);
    check("R7 full freezes", int'(depth_limit), 5);
    run_window(0, 64, 0, 0);
    check("R9 all useful lowers", int'(depth_limit), 4);
    run_window(21, 43, 0, 0);
    check("R9 2x21 not above 43", int'(depth_limit), 3);
    run_window(22, 42, 0, 0);
    check("R8 2x22 above 42", int'(depth_limit), 4);
    run_window(0, 0, 64, 0);
    check("R6 both pulses count late", int'(depth_limit), 5);
    for (int w = 0; w < 13; w++) run_window(64, 0, 0, 0);
    check("R10 clamp at top", int'(depth_limit), 16);

    // fill at the top, then lower the limit under the tokens
    for (int i = 0; i < 16; i++) step(1, 0, 0, 0, 0, "R2");
    for (int w = 0; w < 16; w++) run_window(0, 64, 0, 0);
    check("R10 clamp at bottom", int'(depth_limit), 1);
    check("R11 tokens kept", int'(occupancy), 16);
    step(1, 0, 0, 0, 0, "R3");
    check("R3 put above limit", int'(occupancy), 16);
    for (int i = 0; i < 16; i++) step(0, 1, 0, 0, 0, "R2");

    // constrained random traffic against the reference functions
    void'($urandom(32'd20240611));
    for (int c = 0; c < 4000; c++) begin
      bit p, g, l, u, f;
      p = ($urandom % 100) < 55;
      g = ($urandom % 100) < 45;
      l = ($urandom % 100) < 30;
      u = ($urandom % 100) < 40;
      f = ($urandom % 100) < 20;
      step(p, g, l, u, f, "R2 random");
    end

    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule